// File: doc/BRIEF.md
# Directory DMA Write Controller

This block sits in a coherence directory and owns one cache line while a DMA agent writes to it. When a write arrives and the line is idle, the block records the transaction identifier. It then asks memory for the current line and sends invalidating probes to every core at the same time. Two things must happen before the write can finish: the memory data must come back (either from DRAM or as a hit in the lower-level cache), and every probed core must respond. These two events are independent and may arrive in either order, or in the same cycle.

Once both have happened, the block finishes the write. It requests a writeback of the merged line and acknowledges the DMA agent with the saved identifier. It also gives a single wake pulse so that requests held off while the line was busy can retry. Only one DMA transaction per line is outstanding at a time. While busy, the block holds off core requests, DMA reads, further DMA writes and victim writebacks. Memory writeback acks are consumed in every state. The byte merge itself happens outside this block. The block only reports whether any probe returned data, so that the merge logic knows the probed copy takes precedence.

Top module: `dma_wr_dir_ctrl`

## Requirements
- R1: After reset the line is idle. `busy` is 0 and `wr_ready` is 1, and the pulse outputs `mem_rd_req`, `probe_inv_req`, `line_wb_valid`, `dma_ack_valid` and `wake` are 0.
- R2: A write is accepted at a rising edge where `wr_valid` is 1 and the line is idle. In the following cycle `mem_rd_req` and `probe_inv_req` are each 1 for exactly one cycle, and `busy` is 1.
- R3: Probe completion requires exactly NUM_CORES probe responses. Responses received while idle, or after the count has run out, have no effect.
- R4: If all probes complete before memory data, the block waits for memory. `dma_ack_valid` rises in the cycle after the edge at which memory data or a lower-level cache hit is received.
- R5: If memory data (or a lower-level cache hit) comes first, `dma_ack_valid` rises two cycles after the edge at which the last probe response is received.
- R6: If memory data arrives in the cycle after the last probe response, the block finishes at that edge. `dma_ack_valid` is 1 in the next cycle.
- R7: `dma_ack_id` equals the `wr_id` sampled at acceptance. Later changes of `wr_id` do not alter it.
- R8: While `busy` is 1, `wr_ready` is 0, and each of `core_req_stall`, `dma_rd_stall` and `vic_stall` follows its request valid. While idle, all three stall outputs are 0.
- R9: On completion, `line_wb_valid`, `dma_ack_valid` and `wake` are 1 together for exactly one cycle, and `busy` is 0 in that cycle.
- R10: `wb_ack_pop` follows `wb_ack_valid` in every state.
- R11: `line_wb_probe_data` is 1 with the writeback if and only if at least one counted probe response of that transaction had `prb_resp_data` set.
- R12: Memory data or a lower-level cache hit received while idle, or while waiting only on probes, neither finishes the transaction nor starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | DMA write request |
| wr_id | input | ID_W | DMA transaction identifier |
| wr_ready | output | 1 | Line idle, write can be accepted |
| dma_rd_valid | input | 1 | DMA read request for the line |
| dma_rd_stall | output | 1 | DMA read held off |
| core_req_valid | input | 1 | Core read, ownership or upgrade request |
| core_req_stall | output | 1 | Core request held off |
| vic_valid | input | 1 | Dirty or clean victim writeback |
| vic_stall | output | 1 | Victim held off |
| mem_rd_req | output | 1 | One-cycle memory read request |
| probe_inv_req | output | 1 | One-cycle invalidating probe broadcast |
| mem_data_valid | input | 1 | Memory data returned |
| llc_hit_valid | input | 1 | Lower-level cache supplied the line |
| prb_resp_valid | input | 1 | One probe response |
| prb_resp_data | input | 1 | The probe response carries data |
| wb_ack_valid | input | 1 | Memory writeback ack |
| wb_ack_pop | output | 1 | Writeback ack consumed |
| line_wb_valid | output | 1 | One-cycle writeback of merged line |
| line_wb_probe_data | output | 1 | Probe data takes part in the merge |
| dma_ack_valid | output | 1 | One-cycle DMA write ack |
| dma_ack_id | output | ID_W | Identifier returned with the ack |
| wake | output | 1 | One-cycle release of stalled requests |
| busy | output | 1 | A transaction is in flight |

## Verification
The write path is driven in three arrival orders: probes completing before memory data, memory data before probes (both as a DRAM return and as a lower-level cache hit), and memory data in the cycle right after the final probe response. Each order makes the ack appear in a different cycle, so a wrong transition shows up as an early or late ack. Separate runs send probe responses with and without data to show the writeback flag, send surplus probe responses and stray memory data to show they are ignored, and change `wr_id` mid-flight to show the identifier is captured at acceptance. Every request type is raised both while busy and while idle to tell correct stalling from constant stalling.

// File: rtl/dma_wr_dir_ctrl.sv
module dma_wr_dir_ctrl #(
  parameter int NUM_CORES = 4,
  parameter int ID_W      = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  input  logic [ID_W-1:0] wr_id,
  output logic            wr_ready,
  input  logic            dma_rd_valid,
  output logic            dma_rd_stall,
  input  logic            core_req_valid,
  output logic            core_req_stall,
  input  logic            vic_valid,
  output logic            vic_stall,
  output logic            mem_rd_req,
  output logic            probe_inv_req,
  input  logic            mem_data_valid,
  input  logic            llc_hit_valid,
  input  logic            prb_resp_valid,
  input  logic            prb_resp_data,
  input  logic            wb_ack_valid,
  output logic            wb_ack_pop,
  output logic            line_wb_valid,
  output logic            line_wb_probe_data,
  output logic            dma_ack_valid,
  output logic [ID_W-1:0] dma_ack_id,
  output logic            wake,
  output logic            busy
);

  localparam int CNT_W = $clog2(NUM_CORES + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT_PM, S_WAIT_M, S_WAIT_P} st_t;

  st_t             state;
  logic [CNT_W-1:0] cnt;
  logic            done_q;
  logic            pdata_q;
  logic [ID_W-1:0] id_q;

  logic accept, mem_in, wait_prb, take_resp, finish;

  assign busy      = (state != S_IDLE);
  assign wr_ready  = !busy;
  assign accept    = wr_valid && !busy;
  assign mem_in    = mem_data_valid || llc_hit_valid;
  assign wait_prb  = (state == S_WAIT_PM) || (state == S_WAIT_P);
  assign take_resp = prb_resp_valid && wait_prb && (cnt != '0);
  assign finish    = ((state == S_WAIT_M)  && mem_in) ||
                     ((state == S_WAIT_P)  && done_q) ||
                     ((state == S_WAIT_PM) && mem_in && done_q);

  assign core_req_stall = busy && core_req_valid;
  assign dma_rd_stall   = busy && dma_rd_valid;
  assign vic_stall      = busy && vic_valid;
  assign wb_ack_pop     = wb_ack_valid;
  assign dma_ack_id     = id_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE:    if (accept) state <= S_WAIT_PM;
        S_WAIT_PM: begin
          if (mem_in && done_q) state <= S_IDLE;
          else if (mem_in)      state <= S_WAIT_P;
          else if (done_q)      state <= S_WAIT_M;
        end
        S_WAIT_M:  if (mem_in) state <= S_IDLE;
        S_WAIT_P:  if (done_q) state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      done_q  <= 1'b0;
      pdata_q <= 1'b0;
      id_q    <= '0;
    end else begin
      done_q <= take_resp && (cnt == CNT_W'(1));
      if (accept) begin
        cnt     <= CNT_W'(NUM_CORES);
        pdata_q <= 1'b0;
        id_q    <= wr_id;
      end else if (take_resp) begin
        cnt <= cnt - CNT_W'(1);
        if (prb_resp_data) pdata_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_rd_req         <= 1'b0;
      probe_inv_req      <= 1'b0;
      line_wb_valid      <= 1'b0;
      line_wb_probe_data <= 1'b0;
      dma_ack_valid      <= 1'b0;
      wake               <= 1'b0;
    end else begin
      mem_rd_req         <= accept;
      probe_inv_req      <= accept;
      line_wb_valid      <= finish;
      line_wb_probe_data <= finish && pdata_q;
      dma_ack_valid      <= finish;
      wake               <= finish;
    end
  end

  a_r2_issue_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> $past(wr_valid && wr_ready));
  a_r2_issue_once: assert property (@(posedge clk) disable iff (!rst_n)
    probe_inv_req |=> !probe_inv_req);
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(NUM_CORES));
  a_r9_wake_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (dma_ack_valid && line_wb_valid && !busy));
  a_r4_ack_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ack_valid |-> $past(busy));
  a_r8_no_stall_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!core_req_stall && !vic_stall && !dma_rd_stall));
  a_r7_id_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(dma_ack_id));

endmodule

// File: tb/dma_wr_dir_ctrl_tb.sv
module dma_wr_dir_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int IW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 0, dma_rd_valid = 0, core_req_valid = 0, vic_valid = 0;
  logic [IW-1:0] wr_id = '0;
  logic mem_data_valid = 0, llc_hit_valid = 0, prb_resp_valid = 0, prb_resp_data = 0, wb_ack_valid = 0;
  logic wr_ready, dma_rd_stall, core_req_stall, vic_stall, mem_rd_req, probe_inv_req;
  logic wb_ack_pop, line_wb_valid, line_wb_probe_data, dma_ack_valid, wake, busy;
  logic [IW-1:0] dma_ack_id;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_wr_dir_ctrl #(.NUM_CORES(NC), .ID_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_id(wr_id), .wr_ready(wr_ready),
    .dma_rd_valid(dma_rd_valid), .dma_rd_stall(dma_rd_stall),
    .core_req_valid(core_req_valid), .core_req_stall(core_req_stall),
    .vic_valid(vic_valid), .vic_stall(vic_stall),
    .mem_rd_req(mem_rd_req), .probe_inv_req(probe_inv_req),
    .mem_data_valid(mem_data_valid), .llc_hit_valid(llc_hit_valid),
    .prb_resp_valid(prb_resp_valid), .prb_resp_data(prb_resp_data),
    .wb_ack_valid(wb_ack_valid), .wb_ack_pop(wb_ack_pop),
    .line_wb_valid(line_wb_valid), .line_wb_probe_data(line_wb_probe_data),
    .dma_ack_valid(dma_ack_valid), .dma_ack_id(dma_ack_id),
    .wake(wake), .busy(busy));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  // accept a write and check the issue pulses (R2)
  task automatic start(input logic [IW-1:0] id);
    wr_valid = 1; wr_id = id;
    tick();
    wr_valid = 0;
    chk("R2 mem_rd_req", mem_rd_req, 1);
    chk("R2 probe_inv_req", probe_inv_req, 1);
    chk("R2 busy", busy, 1);
    tick();
    chk("R2 mem_rd one cycle", mem_rd_req, 0);
    chk("R2 probe one cycle", probe_inv_req, 0);
  endtask

  task automatic probes(input int n, input logic with_data);
    for (int i = 0; i < n; i++) begin
      prb_resp_valid = 1; prb_resp_data = with_data && (i == 1);
      tick();
    end
    prb_resp_valid = 0; prb_resp_data = 0;
  endtask

  task automatic expect_done(input string req, input logic [IW-1:0] id, input logic pd);
    chk({req, " ack"}, dma_ack_valid, 1);
    chk("R9 wb with ack", line_wb_valid, 1);
    chk("R9 wake with ack", wake, 1);
    chk("R9 idle at ack", busy, 0);
    chk("R7 ack id", dma_ack_id, id);
    chk("R11 probe data flag", line_wb_probe_data, pd);
    tick();
    chk("R9 ack one cycle", dma_ack_valid, 0);
    chk("R9 wake one cycle", wake, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 wr_ready", wr_ready, 1);
    chk("R1 pulses", {mem_rd_req, probe_inv_req, line_wb_valid, dma_ack_valid, wake}, 0);
  endtask

  task automatic t_probes_first();
    start(6'h11);
    probes(NC, 1'b0);
    tick();                         // completion event consumed
    chk("R4 no ack before memory", dma_ack_valid, 0);
    chk("R4 still busy", busy, 1);
    tick(); tick();
    chk("R4 waits for memory", busy, 1);
    mem_data_valid = 1; tick(); mem_data_valid = 0;
    expect_done("R4", 6'h11, 1'b0);
  endtask

  task automatic t_mem_first(input logic use_llc);
    start(6'h22);
    if (use_llc) llc_hit_valid = 1; else mem_data_valid = 1;
    tick();
    llc_hit_valid = 0; mem_data_valid = 0;
    chk("R5 busy after memory", busy, 1);
    chk("R5 no early ack", dma_ack_valid, 0);
    probes(NC - 1, 1'b1);
    mem_data_valid = 1; tick(); mem_data_valid = 0;   // stray data while waiting on probes
    chk("R12 stray data no finish", dma_ack_valid, 0);
    probes(1, 1'b0);
    chk("R5 not yet", dma_ack_valid, 0);
    tick();
    expect_done("R5", 6'h22, 1'b1);
  endtask

  task automatic t_same_cycle();
    start(6'h05);
    wr_id = 6'h3f;                   // must not alter captured id
    probes(NC, 1'b0);
    mem_data_valid = 1; tick(); mem_data_valid = 0;
    expect_done("R6", 6'h05, 1'b0);
  endtask

  task automatic t_surplus_and_idle();
    prb_resp_valid = 1; mem_data_valid = 1; tick();
    prb_resp_valid = 0; mem_data_valid = 0;
    chk("R12 idle data no start", busy, 0);
    chk("R3 idle probe ignored", dma_ack_valid, 0);
    start(6'h0a);
    probes(NC + 2, 1'b0);           // two surplus responses
    chk("R3 surplus ignored", busy, 1);
    mem_data_valid = 1; tick(); mem_data_valid = 0;
    expect_done("R3", 6'h0a, 1'b0);
    start(6'h0b);
    probes(NC - 1, 1'b0);
    mem_data_valid = 1; tick(); mem_data_valid = 0;
    tick(); tick();
    chk("R3 one short keeps busy", busy, 1);
    probes(1, 1'b0); tick();
    expect_done("R3 final", 6'h0b, 1'b0);
  endtask

  task automatic t_stalls();
    core_req_valid = 1; dma_rd_valid = 1; vic_valid = 1; wb_ack_valid = 1;
    tick();
    chk("R8 idle core", core_req_stall, 0);
    chk("R8 idle dma rd", dma_rd_stall, 0);
    chk("R8 idle vic", vic_stall, 0);
    chk("R10 pop idle", wb_ack_pop, 1);
    start(6'h33);
    chk("R8 core stalled", core_req_stall, 1);
    chk("R8 dma rd stalled", dma_rd_stall, 1);
    chk("R8 vic stalled", vic_stall, 1);
    chk("R8 wr not ready", wr_ready, 0);
    chk("R10 pop busy", wb_ack_pop, 1);
    wb_ack_valid = 0; vic_valid = 0; #1;
    chk("R10 pop follows", wb_ack_pop, 0);
    chk("R8 vic follows", vic_stall, 0);
    wr_valid = 1; wr_id = 6'h01;
    probes(NC, 1'b0);
    mem_data_valid = 1; tick(); mem_data_valid = 0; wr_valid = 0;
    chk("R8 released", core_req_stall, 0);
    expect_done("R8 second write ignored", 6'h33, 1'b0);
    chk("R8 no new start", busy, 0);
    core_req_valid = 0; dma_rd_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    t_reset();
    t_probes_first();
    t_mem_first(1'b0);
    t_mem_first(1'b1);
    t_same_cycle();
    t_surplus_and_idle();
    t_stalls();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule